// File: doc/BRIEF.md
# Staged Power-Gating Wake-Up Sequencer

This controller runs the power transitions of one switched logic domain. It drives a weak pre-charge switch, a bank of N strong switch segments, an output clamp and the save and restore strobes of the retention registers. A wake request brings the domain up in two passes. First the weak switch charges the virtual rail. Then the strong segments close one at a time, lowest index first. A request/acknowledge handshake gates every stage of this sequence. After the last segment the controller restores state, opens the clamp and reports the domain ready.

A sleep request reverses this. The controller clamps the outputs, saves state, opens the strong segments one per cycle from the highest index down, and then opens the weak switch. A request in the opposite direction that arrives during a sequence is kept pending and is served after the sequence ends. The controller can also request sleep by itself after a set number of consecutive idle cycles. If an acknowledge does not arrive in time, the controller freezes in the current stage and raises an error flag.

Top module: `pgw_ctrl`

## Requirements
- R1: After synchronous reset the domain is asleep: `clamp_en`=1, `asleep`=1, and `precharge_en`, `strong_en`, `turnon_req`, `ready`, `busy` and `fault` are all 0.
- R2: One cycle after a wake request is taken in sleep, `precharge_en` and `turnon_req` go high while `strong_en` stays 0. The controller stays in this stage until it samples `precharge_ack` high.
- R3: Strong segment k (bit k of `strong_en`) closes only after segment k-1 and only after an acknowledge on `strong_ack[k-1]`. Seen as a count, the segment with index k is enabled one cycle after `strong_ack` bit k-1 is sampled high while that segment is awaited. `strong_en` is always a thermometer code, and its number of set bits changes by at most one per cycle. Acknowledge bits other than the awaited one, and `precharge_ack` during the strong pass, have no effect.
- R4: After the acknowledge of the last segment, `ret_restore` pulses for one cycle with the clamp still on. In the next cycle `clamp_en` falls with `ready`=0. One cycle later `ready`=1.
- R5: A sleep request taken while ready gives, one cycle per step: clamp on with all segments closed, a one-cycle `ret_save` pulse, then `strong_en` holding N, N-1, …, 1 lowest bits set, then a cycle with everything open and `asleep`=0, then `asleep`=1.
- R6: A sleep request pulsed during a wake sequence, or a wake request pulsed during a sleep sequence, is held. The reverse sequence starts at the first clock edge after the end state is reached, so the end state is seen for exactly one cycle.
- R7: If an awaited acknowledge is still missing after TMO_CYC cycles in a stage, `fault` rises and stays high. All switch and clamp outputs then hold, even if the acknowledge arrives later.
- R8: While ready, with `auto_en`=1 and `idle_limit`=L>0, the controller starts the sleep sequence at the L-th consecutive clock edge with `idle_hint` high. With L=0 no automatic entry happens.
- R9: A wake request sampled while the idle count runs clears the count. A full L further consecutive idle edges are then needed for automatic entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Request to power the domain up (pulse or level) |
| sleep_req | input | 1 | Request to power the domain down (pulse or level) |
| idle_hint | input | 1 | Domain reports it has no work this cycle |
| auto_en | input | 1 | Enables idle-driven sleep entry |
| idle_limit | input | IDLE_W | Consecutive idle cycles before automatic sleep; 0 disables |
| precharge_ack | input | 1 | Acknowledge of the weak pre-charge stage |
| strong_ack | input | N | Per-segment acknowledge of the strong switches |
| precharge_en | output | 1 | Weak pre-charge switch enable |
| strong_en | output | N | Strong segment enables, thermometer coded from bit 0 |
| turnon_req | output | 1 | Turn-on request, high while an acknowledge is awaited |
| clamp_en | output | 1 | Output isolation clamp of the domain |
| ret_save | output | 1 | Retention save strobe |
| ret_restore | output | 1 | Retention restore strobe |
| ready | output | 1 | Domain fully powered and unclamped |
| asleep | output | 1 | Domain fully powered down |
| busy | output | 1 | A sequence is in progress |
| fault | output | 1 | Acknowledge timeout, sticky until reset |

## Verification
The properties assume that each acknowledge input is a level that the switch network raises on its own. They do not assume that an acknowledge comes at a particular time, nor that other acknowledge bits stay low. So the stimulus puts random values on every acknowledge bit that is not awaited, and waits a random number of cycles before it raises the awaited one. Requests arrive as single-cycle pulses. Some of them are placed inside a running sequence, to exercise the holding of opposite requests. The idle hint is driven only when the domain is ready, and it stays high for runs of a known length.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [3:0] {
        ST_SLEEP,
        ST_UP_WEAK,
        ST_UP_SEG,
        ST_UP_RESTORE,
        ST_UP_UNCLAMP,
        ST_ACTIVE,
        ST_DN_CLAMP,
        ST_DN_SAVE,
        ST_DN_OPEN,
        ST_DN_WEAK
    } pgw_state_e;

    typedef struct packed {
        logic precharge;
        logic turnon_req;
        logic clamp;
        logic save;
        logic restore;
        logic ready;
        logic asleep;
        logic full_bank;
        logic partial_bank;
    } pgw_ctl_t;

    function automatic logic awaiting_ack(pgw_state_e s);
        return (s == ST_UP_WEAK) || (s == ST_UP_SEG);
    endfunction

    function automatic pgw_ctl_t decode_state(pgw_state_e s);
        pgw_ctl_t c;
        c = '0;
        c.clamp = 1'b1;
        unique case (s)
            ST_SLEEP:      c.asleep = 1'b1;
            ST_UP_WEAK:    begin c.precharge = 1'b1; c.turnon_req = 1'b1; end
            ST_UP_SEG:     begin c.precharge = 1'b1; c.turnon_req = 1'b1; c.partial_bank = 1'b1; end
            ST_UP_RESTORE: begin c.precharge = 1'b1; c.full_bank = 1'b1; c.restore = 1'b1; end
            ST_UP_UNCLAMP: begin c.precharge = 1'b1; c.full_bank = 1'b1; c.clamp = 1'b0; end
            ST_ACTIVE:     begin c.precharge = 1'b1; c.full_bank = 1'b1; c.clamp = 1'b0; c.ready = 1'b1; end
            ST_DN_CLAMP:   begin c.precharge = 1'b1; c.full_bank = 1'b1; end
            ST_DN_SAVE:    begin c.precharge = 1'b1; c.full_bank = 1'b1; c.save = 1'b1; end
            ST_DN_OPEN:    begin c.precharge = 1'b1; c.partial_bank = 1'b1; end
            ST_DN_WEAK:    c.clamp = 1'b1;
            default:       c.asleep = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pgw_stage_timer.sv
module pgw_stage_timer #(
    parameter int TMO_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic waiting,
    input  logic advance,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !waiting || advance) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = waiting && !advance && (cnt_q == LAST);
endmodule

// File: rtl/pgw_idle_count.sv
module pgw_idle_count #(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              armed,
    input  logic              idle_hint,
    input  logic              cancel,
    input  logic [IDLE_W-1:0] limit,
    output logic              trigger
);
    logic [IDLE_W-1:0] cnt_q;
    logic              counting;

    assign counting = armed && idle_hint && !cancel;

    always_ff @(posedge clk) begin
        if (rst || !counting) begin
            cnt_q <= '0;
        end else if (cnt_q != {IDLE_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trigger = counting && (limit != '0) && (cnt_q >= limit - 1'b1);
endmodule

// File: rtl/pgw_therm.sv
module pgw_therm #(
    parameter int N  = 4,
    parameter int CW = 3
) (
    input  logic [CW-1:0] level,
    output logic [N-1:0]  bank
);
    for (genvar i = 0; i < N; i++) begin : g_seg
        assign bank[i] = (level > CW'(i));
    end
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
    import pgw_pkg::*;
#(
    parameter int N       = 4,
    parameter int TMO_CYC = 16,
    parameter int IDLE_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_req,
    input  logic              sleep_req,
    input  logic              idle_hint,
    input  logic              auto_en,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              precharge_ack,
    input  logic [N-1:0]      strong_ack,
    output logic              precharge_en,
    output logic [N-1:0]      strong_en,
    output logic              turnon_req,
    output logic              clamp_en,
    output logic              ret_save,
    output logic              ret_restore,
    output logic              ready,
    output logic              asleep,
    output logic              busy,
    output logic              fault
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] NSEG = CW'(N);

    pgw_state_e  state_q, state_d;
    logic [CW-1:0] lvl_q, lvl_d;
    logic        fault_q, fault_d;
    logic        wake_pend_q, sleep_pend_q;
    logic        want_wake, want_sleep;
    logic        idle_trig, stage_ack, tmo, waiting;
    logic        seg_ack_sel;
    logic [CW-1:0] bank_level;
    pgw_ctl_t    ctl;

    always_comb begin
        seg_ack_sel = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (lvl_q == CW'(i + 1)) seg_ack_sel = strong_ack[i];
        end
    end

    assign stage_ack  = (state_q == ST_UP_WEAK) ? precharge_ack :
                        (state_q == ST_UP_SEG)  ? seg_ack_sel : 1'b0;
    assign waiting    = awaiting_ack(state_q) && !fault_q;
    assign want_wake  = wake_pend_q || wake_req;
    assign want_sleep = sleep_pend_q || sleep_req || idle_trig;

    pgw_stage_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .waiting (waiting),
        .advance (stage_ack),
        .expired (tmo)
    );

    pgw_idle_count #(.IDLE_W(IDLE_W)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .armed     (auto_en && (state_q == ST_ACTIVE)),
        .idle_hint (idle_hint),
        .cancel    (wake_req),
        .limit     (idle_limit),
        .trigger   (idle_trig)
    );

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        fault_d = fault_q;
        if (!fault_q) begin
            unique case (state_q)
                ST_SLEEP: if (want_wake) state_d = ST_UP_WEAK;
                ST_UP_WEAK: begin
                    if (stage_ack) begin
                        state_d = ST_UP_SEG;
                        lvl_d   = CW'(1);
                    end else if (tmo) begin
                        fault_d = 1'b1;
                    end
                end
                ST_UP_SEG: begin
                    if (stage_ack) begin
                        if (lvl_q == NSEG) state_d = ST_UP_RESTORE;
                        else               lvl_d   = lvl_q + 1'b1;
                    end else if (tmo) begin
                        fault_d = 1'b1;
                    end
                end
                ST_UP_RESTORE: state_d = ST_UP_UNCLAMP;
                ST_UP_UNCLAMP: state_d = ST_ACTIVE;
                ST_ACTIVE:     if (want_sleep) state_d = ST_DN_CLAMP;
                ST_DN_CLAMP:   state_d = ST_DN_SAVE;
                ST_DN_SAVE: begin
                    state_d = ST_DN_OPEN;
                    lvl_d   = NSEG;
                end
                ST_DN_OPEN: begin
                    lvl_d = lvl_q - 1'b1;
                    if (lvl_q == CW'(1)) state_d = ST_DN_WEAK;
                end
                ST_DN_WEAK:    state_d = ST_SLEEP;
                default:       state_d = ST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_SLEEP;
            lvl_q        <= '0;
            fault_q      <= 1'b0;
            wake_pend_q  <= 1'b0;
            sleep_pend_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            lvl_q        <= lvl_d;
            fault_q      <= fault_d;
            wake_pend_q  <= want_wake && (state_q != ST_SLEEP) && (state_q != ST_ACTIVE);
            sleep_pend_q <= (sleep_pend_q || sleep_req) &&
                            (state_q != ST_SLEEP) && (state_q != ST_ACTIVE);
        end
    end

    assign ctl        = decode_state(state_q);
    assign bank_level = ctl.full_bank ? NSEG : (ctl.partial_bank ? lvl_q : '0);

    pgw_therm #(.N(N), .CW(CW)) u_therm (
        .level (bank_level),
        .bank  (strong_en)
    );

    assign precharge_en = ctl.precharge;
    assign turnon_req   = ctl.turnon_req;
    assign clamp_en     = ctl.clamp;
    assign ret_save     = ctl.save;
    assign ret_restore  = ctl.restore;
    assign ready        = ctl.ready;
    assign asleep       = ctl.asleep;
    assign busy         = !ctl.ready && !ctl.asleep;
    assign fault        = fault_q;
endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         precharge_ack,
    input logic [N-1:0] strong_ack,
    input logic         precharge_en,
    input logic [N-1:0] strong_en,
    input logic         turnon_req,
    input logic         clamp_en,
    input logic         ret_save,
    input logic         ready,
    input logic         fault
);
    AST_BANK_THERMO: assert property (@(posedge clk) disable iff (rst)
        ((strong_en & (strong_en + 1'b1)) == '0)); // R3

    AST_BANK_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($countones(strong_en) <= $countones($past(strong_en)) + 1) &&
                  ($countones(strong_en) + 1 >= $countones($past(strong_en))))); // R3

    AST_WEAK_FIRST: assert property (@(posedge clk) disable iff (rst)
        (|strong_en) |-> precharge_en); // R2

    AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (turnon_req && !precharge_ack && !(|strong_ack)) |=>
            ($stable(strong_en) && $stable(precharge_en))); // R2

    AST_CLAMP_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        (strong_en != {N{1'b1}}) |-> clamp_en); // R5

    AST_SAVE_POWERED: assert property (@(posedge clk) disable iff (rst)
        ret_save |-> (clamp_en && (strong_en == {N{1'b1}}))); // R5

    AST_READY_FULL: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!clamp_en && (strong_en == {N{1'b1}}))); // R4

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        fault |=> (fault && $stable(strong_en) && $stable(clamp_en))); // R7
endmodule

bind pgw_ctrl pgw_ctrl_chk #(.N(N)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .precharge_ack (precharge_ack),
    .strong_ack    (strong_ack),
    .precharge_en  (precharge_en),
    .strong_en     (strong_en),
    .turnon_req    (turnon_req),
    .clamp_en      (clamp_en),
    .ret_save      (ret_save),
    .ready         (ready),
    .fault         (fault)
);

// File: tb/pgw_ctrl_tb.sv
module pgw_ctrl_tb;
    localparam int N       = 4;
    localparam int TMO_CYC = 16;
    localparam int IDLE_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wake_req = 1'b0, sleep_req = 1'b0, idle_hint = 1'b0, auto_en = 1'b0;
    logic [IDLE_W-1:0] idle_limit = '0;
    logic              precharge_ack = 1'b0;
    logic [N-1:0]      strong_ack = '0;
    logic              precharge_en, turnon_req, clamp_en, ret_save, ret_restore;
    logic              ready, asleep, busy, fault;
    logic [N-1:0]      strong_en;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    pgw_ctrl #(.N(N), .TMO_CYC(TMO_CYC), .IDLE_W(IDLE_W)) u_dut (
        .clk(clk), .rst(rst), .wake_req(wake_req), .sleep_req(sleep_req),
        .idle_hint(idle_hint), .auto_en(auto_en), .idle_limit(idle_limit),
        .precharge_ack(precharge_ack), .strong_ack(strong_ack),
        .precharge_en(precharge_en), .strong_en(strong_en), .turnon_req(turnon_req),
        .clamp_en(clamp_en), .ret_save(ret_save), .ret_restore(ret_restore),
        .ready(ready), .asleep(asleep), .busy(busy), .fault(fault)
    );

    function automatic logic [N-1:0] therm(input int k);
        return N'((64'd1 << k) - 64'd1);
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_wake(input bit use_req, input bit sleep_mid);
        wake_req = use_req;
        step();
        wake_req = 1'b0;
        chk("R2", "precharge on", precharge_en, 1);
        chk("R2", "turnon_req", turnon_req, 1);
        chk("R2", "bank open", strong_en, 0);
        for (int d = $urandom % 4; d > 0; d--) begin
            strong_ack = N'($urandom);
            step();
            chk("R2", "wait precharge ack", strong_en, 0);
        end
        strong_ack = '0;
        precharge_ack = 1'b1;
        step();
        precharge_ack = 1'b0;
        chk("R3", "first segment", strong_en, therm(1));
        for (int i = 0; i < N; i++) begin
            for (int d = $urandom % 4; d > 0; d--) begin
                strong_ack = N'($urandom) & ~(N'(1) << i);
                precharge_ack = 1'($urandom);
                step();
                chk("R3", "segment held without own ack", strong_en, therm(i + 1));
            end
            precharge_ack = 1'b0;
            strong_ack = N'(1) << i;
            sleep_req = sleep_mid && (i == 0);
            step();
            strong_ack = '0;
            sleep_req = 1'b0;
            if (i < N - 1) chk("R3", "next segment", strong_en, therm(i + 2));
        end
        chk("R4", "restore pulse", ret_restore, 1);
        chk("R4", "clamp during restore", clamp_en, 1);
        chk("R4", "full bank", strong_en, therm(N));
        step();
        chk("R4", "restore ends", ret_restore, 0);
        chk("R4", "clamp released", clamp_en, 0);
        chk("R4", "not yet ready", ready, 0);
        step();
        chk("R4", "ready", ready, 1);
        chk("R4", "not busy", busy, 0);
    endtask

    task automatic do_sleep(input bit use_req, input bit wake_mid);
        sleep_req = use_req;
        step();
        sleep_req = 1'b0;
        chk("R5", "clamp first", clamp_en, 1);
        chk("R5", "bank still full", strong_en, therm(N));
        chk("R5", "ready drops", ready, 0);
        chk("R5", "no save yet", ret_save, 0);
        step();
        chk("R5", "save pulse", ret_save, 1);
        chk("R5", "bank full at save", strong_en, therm(N));
        for (int k = N; k >= 1; k--) begin
            wake_req = wake_mid && (k == N);
            step();
            wake_req = 1'b0;
            chk("R5", "descending open", strong_en, therm(k));
            chk("R5", "save ends", ret_save, 0);
        end
        step();
        chk("R5", "bank open", strong_en, 0);
        chk("R5", "weak off", precharge_en, 0);
        chk("R5", "not yet asleep", asleep, 0);
        step();
        chk("R5", "asleep", asleep, 1);
        chk("R5", "clamp in sleep", clamp_en, 1);
    endtask

    initial begin : watchdog
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_err++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 20000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step();
        rst = 1'b0;
        chk("R1", "asleep", asleep, 1);
        chk("R1", "clamp", clamp_en, 1);
        chk("R1", "precharge", precharge_en, 0);
        chk("R1", "bank", strong_en, 0);
        chk("R1", "turnon_req", turnon_req, 0);
        chk("R1", "ready", ready, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "fault", fault, 0);

        for (int r = 0; r < 6; r++) begin
            do_wake(1'b1, 1'b0);
            repeat ($urandom % 3) step();
            do_sleep(1'b1, 1'b0);
        end

        // R6: sleep pulsed during wake, wake pulsed during sleep
        do_wake(1'b1, 1'b1);
        do_sleep(1'b0, 1'b1);
        do_wake(1'b0, 1'b0);
        chk("R6", "wake held through sleep", ready, 1);

        // R8: automatic entry after L idle edges
        auto_en = 1'b1;
        idle_limit = 8'd5;
        idle_hint = 1'b1;
        repeat (4) begin
            step();
            chk("R8", "still ready before limit", ready, 1);
        end
        do_sleep(1'b0, 1'b0);
        idle_hint = 1'b0;

        // R9: wake request restarts the idle count
        do_wake(1'b1, 1'b0);
        idle_hint = 1'b1;
        repeat (2) step();
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        repeat (4) begin
            step();
            chk("R9", "count restarted", ready, 1);
        end
        do_sleep(1'b0, 1'b0);
        idle_hint = 1'b0;

        // R8: limit zero disables
        do_wake(1'b1, 1'b0);
        idle_limit = '0;
        idle_hint = 1'b1;
        repeat (20) step();
        chk("R8", "limit zero stays ready", ready, 1);
        idle_hint = 1'b0;
        auto_en = 1'b0;
        do_sleep(1'b1, 1'b0);

        // R7: precharge acknowledge timeout
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        repeat (TMO_CYC - 1) step();
        chk("R7", "no fault before limit", fault, 0);
        step();
        chk("R7", "fault at limit", fault, 1);
        precharge_ack = 1'b1;
        step();
        step();
        precharge_ack = 1'b0;
        chk("R7", "fault sticky", fault, 1);
        chk("R7", "bank frozen", strong_en, 0);
        chk("R7", "precharge frozen", precharge_en, 1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1", "reset clears fault", fault, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule